// File: doc/BRIEF.md
# E1 Timeslot-16 Channel Signaling Inserter

This block builds the octet that goes into timeslot 16 of every transmitted E1 frame when channel-associated signaling is in use. It keeps its own 16-frame signaling multiframe counter, advanced by a frame strobe, and has no tie to any CRC-4 multiframe. Frame 0 of the multiframe carries the alignment pattern and the spare/alarm bits. Each later frame carries two 4-bit ABCD signaling nibbles, one for a channel in the lower half of the frame and one for its partner in the upper half.

Each of the 30 voice channels takes its nibble from one of two places: a serial signaling stream that arrives one nibble per timeslot, or a bank of host-written registers. A per-channel source-select vector picks between them. The vector is sampled at each frame strobe and used only from the following frame on, so host data written during the frame in which a channel is switched is not sent yet. When the common-channel-signaling mode input is high, the block passes the incoming timeslot-16 octet through unchanged. A one-cycle pulse marks the start of each signaling multiframe.

Top module: `cas_ts16_inserter`

## Requirements
- R1: The frame counter advances on each `frame_sync` cycle and wraps from 15 to 0. `mf_start` is high for exactly the one cycle after the `frame_sync` that starts frame 0, and is low at all other times.
- R2: In frame 0 with `ccs_mode` low, `ts16_out[7:4]` is 0000.
- R3: In frame 0 with `ccs_mode` low, `ts16_out[3:0]` is {`spare_x[2]`, `rmf_alarm`, `spare_x[1]`, `spare_x[0]`}, from bit 3 down to bit 0.
- R4: In frame n (1 to 15) with `ccs_mode` low, `ts16_out[7:4]` is the ABCD nibble of channel n and `ts16_out[3:0]` is the nibble of channel n+15. Bit 3 of a nibble is A.
- R5: Bit c-1 of the active source vector selects the nibble source for channel c: 0 selects the stream bank and 1 selects the host bank.
- R6: `src_sel` is sampled only in a `frame_sync` cycle. The sampled value selects the sources from the next frame on, and a change in mid-frame does not alter the output during that frame.
- R7: When `sig_stb` is high, `sig_nib` is stored for the channel of timeslot `ts_idx`: timeslot t in 1..15 is channel t, and t in 17..31 is channel t-1. Timeslots 0 and 16 are ignored.
- R8: When `host_we` is high, `host_nib` is stored as the host nibble of channel `host_ch` if that channel is in 1..30. Any other value of `host_ch` is ignored.
- R9: While `ccs_mode` is high, `ts16_out` equals `ts16_in` in the same cycle.
- R10: After reset the counter sits at frame 15, `mf_start` is low, both nibble banks are zero and every channel selects the stream. The first `frame_sync` therefore starts frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | One-cycle strobe that starts a new frame |
| ts_idx | input | 5 | Timeslot number of the current `sig_nib` |
| sig_stb | input | 1 | `sig_nib` is valid for `ts_idx` |
| sig_nib | input | 4 | ABCD nibble from the serial signaling stream |
| host_we | input | 1 | Host bank write enable |
| host_ch | input | 5 | Host write channel, 1..30 |
| host_nib | input | 4 | Host write ABCD nibble |
| src_sel | input | 30 | Per-channel source select, bit c-1 for channel c |
| ccs_mode | input | 1 | High selects pass-through of `ts16_in` |
| spare_x | input | 3 | Spare bits for frame 0 |
| rmf_alarm | input | 1 | Remote multiframe alarm bit for frame 0 |
| ts16_in | input | 8 | Incoming timeslot-16 octet |
| ts16_out | output | 8 | Timeslot-16 octet to transmit |
| mf_start | output | 1 | Multiframe start pulse |

## Verification
The assertions check on every cycle the counter stepping and wrap, the timing of the multiframe pulse, the frame-0 alignment and spare/alarm layout, the pass-through in common-channel mode, and that the source vector is loaded only at a strobe. The scenarios alone show the nibble pairing across frames, the mapping from timeslot to channel with positions 0 and 16 ignored, the rejection of out-of-range host writes, and the one-frame delay of a source switch. Those last behaviours need a host write in the same frame as a switch, followed by a look at the channel's slot one multiframe later.

// File: rtl/cas_ts16_pkg.sv
// Package: shared nibble type and slot-to-channel mapping for the
// timeslot-16 signaling inserter. Assumes two frame halves split at MID.
package cas_ts16_pkg;

    localparam int ABCD_W = 4;

    typedef logic [ABCD_W-1:0] abcd_t;

    // Map a timeslot to a 1-based channel number; 0 means "no channel".
    function automatic logic [4:0] chan_of_slot(input logic [4:0] slot,
                                                 input logic [4:0] mid);
        logic [4:0] ch;
        if (slot == 5'd0 || slot == mid) begin
            ch = 5'd0;
        end else if (slot < mid) begin
            ch = slot;
        end else begin
            ch = slot - 5'd1;
        end
        return ch;
    endfunction

endpackage

// File: rtl/cas_mf_counter.sv
// Signaling multiframe counter with source-select shadow register.
// Counts frames 0..MF_LEN-1 on frame_sync and pulses mf_start for one
// cycle when frame 0 begins. Reset parks the count on the last frame so
// the first strobe opens frame 0. src_sel is copied at each strobe and
// the copy is what the output mux uses, which gives the one-frame delay.
module cas_mf_counter #(
    parameter int MF_LEN = 16,
    parameter int CH_NUM = 30,
    localparam int FRM_W = $clog2(MF_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [CH_NUM-1:0] src_sel,
    output logic [FRM_W-1:0]  frm,
    output logic              mf_start,
    output logic [CH_NUM-1:0] src_shadow
);

    localparam logic [FRM_W-1:0] LAST = FRM_W'(MF_LEN - 1);

    // Frame count: step on strobe, wrap after the last frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm <= LAST;
        end else if (frame_sync) begin
            frm <= (frm == LAST) ? '0 : frm + FRM_W'(1);
        end
    end

    // Multiframe start pulse: set for the first cycle of frame 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mf_start <= 1'b0;
        end else begin
            mf_start <= frame_sync && (frm == LAST);
        end
    end

    // Source-select shadow: loaded only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_shadow <= '0;
        end else if (frame_sync) begin
            src_shadow <= src_sel;
        end
    end

endmodule

// File: rtl/cas_nib_bank.sv
// Bank of per-channel ABCD nibble registers with one write port.
// The channel number is 1-based; a write to 0 or above CH_NUM is dropped.
// All registers are visible at once on a flat output bus.
module cas_nib_bank #(
    parameter int CH_NUM = 30,
    parameter int NIB_W  = 4,
    parameter int CH_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [CH_W-1:0]         ch,
    input  logic [NIB_W-1:0]        din,
    output logic [CH_NUM*NIB_W-1:0] bank
);

    for (genvar i = 0; i < CH_NUM; i++) begin : g_chan
        logic [NIB_W-1:0] nib_q;

        // Channel register: capture din when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_q <= '0;
            end else if (we && (ch == CH_W'(i + 1))) begin
                nib_q <= din;
            end
        end

        assign bank[i*NIB_W +: NIB_W] = nib_q;
    end

endmodule

// File: rtl/cas_ts16_mux.sv
// Output octet builder. For each channel it picks the stream or host
// nibble by the shadowed source bit. It then forms the frame-0 alignment
// octet, the nibble pair of frames 1..HALF, or the pass-through octet in
// common-channel mode. Purely combinational.
module cas_ts16_mux #(
    parameter int CH_NUM = 30,
    parameter int NIB_W  = 4,
    parameter int FRM_W  = 4
) (
    input  logic [FRM_W-1:0]        frm,
    input  logic [CH_NUM-1:0]       src_shadow,
    input  logic [CH_NUM*NIB_W-1:0] strm_bank,
    input  logic [CH_NUM*NIB_W-1:0] host_bank,
    input  logic                    ccs_mode,
    input  logic [2:0]              spare_x,
    input  logic                    rmf_alarm,
    input  logic [2*NIB_W-1:0]      ts16_in,
    output logic [2*NIB_W-1:0]      ts16_out
);

    localparam int HALF = CH_NUM / 2;
    localparam int CH_W = $clog2(CH_NUM);

    logic [NIB_W-1:0] pick [CH_NUM];
    logic [CH_W-1:0]  hi_idx;
    logic [CH_W-1:0]  lo_idx;

    for (genvar i = 0; i < CH_NUM; i++) begin : g_pick
        assign pick[i] = src_shadow[i] ? host_bank[i*NIB_W +: NIB_W]
                                       : strm_bank[i*NIB_W +: NIB_W];
    end

    // Channel indices shown in the current frame.
    always_comb begin
        hi_idx = CH_W'(frm) - CH_W'(1);
        lo_idx = hi_idx + CH_W'(HALF);
    end

    // Octet select: pass-through, alignment frame, or nibble pair.
    always_comb begin
        if (ccs_mode) begin
            ts16_out = ts16_in;
        end else if (frm == '0) begin
            ts16_out = {{NIB_W{1'b0}}, spare_x[2], rmf_alarm, spare_x[1], spare_x[0]};
        end else begin
            ts16_out = {pick[hi_idx], pick[lo_idx]};
        end
    end

endmodule

// File: rtl/cas_ts16_inserter.sv
// Top: E1 timeslot-16 channel-associated signaling inserter.
// Assumes a 32-slot frame with one frame_sync pulse per frame. The serial
// signaling stream delivers one nibble per strobed timeslot; timeslots 0
// and 16 carry no channel. Host writes address channels 1..30.
module cas_ts16_inserter
    import cas_ts16_pkg::*;
#(
    parameter int MF_LEN = 16,
    parameter int CH_NUM = 2 * (MF_LEN - 1),
    parameter int TS_W   = 5,
    localparam int CH_W  = $clog2(CH_NUM),
    localparam int FRM_W = $clog2(MF_LEN),
    localparam int MID   = MF_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [TS_W-1:0]   ts_idx,
    input  logic              sig_stb,
    input  logic [3:0]        sig_nib,
    input  logic              host_we,
    input  logic [CH_W-1:0]   host_ch,
    input  logic [3:0]        host_nib,
    input  logic [CH_NUM-1:0] src_sel,
    input  logic              ccs_mode,
    input  logic [2:0]        spare_x,
    input  logic              rmf_alarm,
    input  logic [7:0]        ts16_in,
    output logic [7:0]        ts16_out,
    output logic              mf_start
);

    logic [FRM_W-1:0]         frm_q;
    logic [CH_NUM-1:0]        src_shadow;
    logic [CH_NUM*ABCD_W-1:0] strm_bank;
    logic [CH_NUM*ABCD_W-1:0] host_bank;
    logic [CH_W-1:0]          strm_ch;
    logic                     strm_we;

    // Stream slot decode: find the channel of the strobed timeslot.
    always_comb begin
        strm_ch = CH_W'(chan_of_slot(5'(ts_idx), 5'(MID)));
        strm_we = sig_stb && (strm_ch != '0);
    end

    cas_mf_counter #(
        .MF_LEN (MF_LEN),
        .CH_NUM (CH_NUM)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .src_sel    (src_sel),
        .frm        (frm_q),
        .mf_start   (mf_start),
        .src_shadow (src_shadow)
    );

    cas_nib_bank #(
        .CH_NUM (CH_NUM),
        .NIB_W  (ABCD_W),
        .CH_W   (CH_W)
    ) u_strm_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (strm_we),
        .ch    (strm_ch),
        .din   (sig_nib),
        .bank  (strm_bank)
    );

    cas_nib_bank #(
        .CH_NUM (CH_NUM),
        .NIB_W  (ABCD_W),
        .CH_W   (CH_W)
    ) u_host_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (host_we),
        .ch    (host_ch),
        .din   (host_nib),
        .bank  (host_bank)
    );

    cas_ts16_mux #(
        .CH_NUM (CH_NUM),
        .NIB_W  (ABCD_W),
        .FRM_W  (FRM_W)
    ) u_mux (
        .frm        (frm_q),
        .src_shadow (src_shadow),
        .strm_bank  (strm_bank),
        .host_bank  (host_bank),
        .ccs_mode   (ccs_mode),
        .spare_x    (spare_x),
        .rmf_alarm  (rmf_alarm),
        .ts16_in    (ts16_in),
        .ts16_out   (ts16_out)
    );

endmodule

// File: rtl/cas_ts16_checker.sv
// Checker for cas_ts16_inserter: multiframe stepping, pulse timing,
// frame-0 layout, pass-through and source shadow loading. Bound below.
module cas_ts16_checker #(
    parameter int MF_LEN = 16,
    parameter int CH_NUM = 30,
    localparam int FRM_W = $clog2(MF_LEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_sync,
    input logic              ccs_mode,
    input logic [2:0]        spare_x,
    input logic              rmf_alarm,
    input logic [7:0]        ts16_in,
    input logic [7:0]        ts16_out,
    input logic              mf_start,
    input logic [FRM_W-1:0]  frm,
    input logic [CH_NUM-1:0] shadow,
    input logic [CH_NUM-1:0] src_sel
);

    localparam logic [FRM_W-1:0] LAST = FRM_W'(MF_LEN - 1);

    AST_FRM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync && (frm == LAST) |=> (frm == '0));                    // R1
    AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(frm));                                   // R1
    AST_MF_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        mf_start |-> (frm == '0) && $past(frame_sync));                  // R1
    AST_MF_PULSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync && (frm == LAST) |=> mf_start);                       // R1
    AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ccs_mode && (frm == '0) |-> (ts16_out[7:4] == 4'b0000));        // R2
    AST_SPARE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !ccs_mode && (frm == '0) |->
        (ts16_out[3:0] == {spare_x[2], rmf_alarm, spare_x[1], spare_x[0]})); // R3
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(shadow));                                // R6
    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (shadow == $past(src_sel)));                      // R6
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        ccs_mode |-> (ts16_out == ts16_in));                             // R9

endmodule

bind cas_ts16_inserter cas_ts16_checker #(
    .MF_LEN (MF_LEN),
    .CH_NUM (CH_NUM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .ccs_mode   (ccs_mode),
    .spare_x    (spare_x),
    .rmf_alarm  (rmf_alarm),
    .ts16_in    (ts16_in),
    .ts16_out   (ts16_out),
    .mf_start   (mf_start),
    .frm        (frm_q),
    .shadow     (src_shadow),
    .src_sel    (src_sel)
);

// File: tb/cas_ts16_inserter_tb.sv
// Bench for cas_ts16_inserter: a behavioural model is updated at each
// rising edge and compared with the outputs at each falling edge.
module cas_ts16_inserter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic [4:0]  ts_idx = '0;
    logic        sig_stb = 1'b0;
    logic [3:0]  sig_nib = '0;
    logic        host_we = 1'b0;
    logic [4:0]  host_ch = '0;
    logic [3:0]  host_nib = '0;
    logic [29:0] src_sel = '0;
    logic        ccs_mode = 1'b0;
    logic [2:0]  spare_x = 3'b111;
    logic        rmf_alarm = 1'b0;
    logic [7:0]  ts16_in = '0;
    logic [7:0]  ts16_out;
    logic        mf_start;

    int checks = 0;
    int errors = 0;

    // Model state
    int         m_frm = 15;
    bit         m_mf = 0;
    logic [3:0] m_strm [31];
    logic [3:0] m_host [31];
    bit         m_shad [31];

    always #4 clk = ~clk;

    cas_ts16_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ts_idx(ts_idx),
        .sig_stb(sig_stb), .sig_nib(sig_nib), .host_we(host_we),
        .host_ch(host_ch), .host_nib(host_nib), .src_sel(src_sel),
        .ccs_mode(ccs_mode), .spare_x(spare_x), .rmf_alarm(rmf_alarm),
        .ts16_in(ts16_in), .ts16_out(ts16_out), .mf_start(mf_start)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_frm = 15;
            m_mf = 0;
            for (int c = 0; c < 31; c++) begin
                m_strm[c] = '0;
                m_host[c] = '0;
                m_shad[c] = 0;
            end
        end else begin
            m_mf = frame_sync && (m_frm == 15);
            if (frame_sync) begin
                m_frm = (m_frm + 1) % 16;
                for (int c = 1; c <= 30; c++) m_shad[c] = src_sel[c-1];
            end
            if (sig_stb) begin
                if (ts_idx >= 1 && ts_idx <= 15) m_strm[ts_idx] = sig_nib;
                else if (ts_idx >= 17) m_strm[ts_idx - 1] = sig_nib;
            end
            if (host_we && host_ch >= 1 && host_ch <= 30) m_host[host_ch] = host_nib;
        end
    end

    function automatic logic [3:0] m_nib(input int c);
        return m_shad[c] ? m_host[c] : m_strm[c];
    endfunction

    // Compare against the model at each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] exp;
            string tag;
            if (ccs_mode) begin
                exp = ts16_in; tag = "R9";
            end else if (m_frm == 0) begin
                exp = {4'b0000, spare_x[2], rmf_alarm, spare_x[1], spare_x[0]};
                tag = (ts16_out[7:4] != 4'b0000) ? "R2" : "R3";
            end else begin
                exp = {m_nib(m_frm), m_nib(m_frm + 15)};
                tag = "R4";
            end
            check(ts16_out == exp, tag, ts16_out, exp);
            check(mf_start == m_mf, "R1", {7'd0, mf_start}, {7'd0, m_mf});
        end
    end

    function automatic logic [3:0] strm_val(input int seed, input int ts);
        return 4'((seed * 7 + ts * 3 + 1) & 15);
    endfunction

    // One frame of 32 timeslots; optional source change, host write and probe.
    task automatic run_frame(input int seed, input int chg_ts,
                             input logic [29:0] new_sel, input int wr_ch,
                             input logic [3:0] wr_nib, input int probe_ts,
                             input bit probe_hi, input logic [3:0] probe_exp,
                             input string tag);
        for (int ts = 0; ts < 32; ts++) begin
            frame_sync = (ts == 0);
            ts_idx = 5'(ts);
            sig_stb = 1'b1;
            sig_nib = strm_val(seed, ts);
            ts16_in = 8'(ts * 9 + seed);
            if (ts == chg_ts) begin
                src_sel = new_sel;
                host_we = (wr_ch >= 0);
                host_ch = 5'(wr_ch);
                host_nib = wr_nib;
            end else begin
                host_we = 1'b0;
            end
            if (ts == probe_ts) begin
                @(negedge clk);
                check((probe_hi ? ts16_out[7:4] : ts16_out[3:0]) == probe_exp, tag,
                      {4'd0, probe_hi ? ts16_out[7:4] : ts16_out[3:0]}, {4'd0, probe_exp});
            end
            @(posedge clk);
            #1;
        end
    endtask

    task automatic plain_frame(input int seed);
        run_frame(seed, -1, src_sel, -1, 4'h0, -1, 1'b1, 4'h0, "R4");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state, frame 15 with empty banks
        @(negedge clk);
        check(mf_start == 1'b0, "R10", {7'd0, mf_start}, 8'h00);
        check(ts16_out == 8'h00, "R10", ts16_out, 8'h00);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // Multiframe 1: all stream-sourced; spare/alarm varied.
        for (int f = 0; f < 16; f++) begin
            if (f == 8) begin spare_x = 3'b010; rmf_alarm = 1'b1; end
            plain_frame(f);
        end

        // Multiframe 2: frame 3 switches channel 3 and 18 to host at ts 5,
        // with host writes the same cycle; output keeps stream (R6).
        for (int f = 0; f < 16; f++) begin
            if (f == 3) begin
                run_frame(20 + f, 5, 30'h0002_0004, 3, ~strm_val(20 + f, 3),
                          20, 1'b1, strm_val(20 + f, 3), "R6");
            end else if (f == 4) begin
                run_frame(20 + f, 2, src_sel, 18, 4'h9, -1, 1'b1, 4'h0, "R8");
            end else if (f == 6) begin
                run_frame(20 + f, 2, src_sel, 0, 4'h5, -1, 1'b1, 4'h0, "R8");
            end else if (f == 7) begin
                run_frame(20 + f, 2, src_sel, 31, 4'h6, -1, 1'b1, 4'h0, "R8");
            end else if (f == 15) begin
                // R7: slot 16 value must not land on channel 15
                run_frame(20 + f, -1, src_sel, -1, 4'h0, 25, 1'b1,
                          strm_val(20 + f, 15), "R7");
            end else begin
                plain_frame(20 + f);
            end
        end

        // Multiframe 3: host values now visible for channels 3 and 18.
        spare_x = 3'b101; rmf_alarm = 1'b0;
        for (int f = 0; f < 16; f++) begin
            if (f == 3) begin
                run_frame(40 + f, -1, src_sel, -1, 4'h0, 10, 1'b1,
                          ~strm_val(20 + 3, 3), "R5");
            end else if (f == 3 + 0) begin
                plain_frame(40 + f);
            end else begin
                plain_frame(40 + f);
            end
        end

        // Multiframe 4: pass-through for the first frames (R9), then back.
        ccs_mode = 1'b1;
        for (int f = 0; f < 16; f++) begin
            if (f == 4) ccs_mode = 1'b0;
            if (f == 3) begin
                run_frame(60 + f, -1, src_sel, -1, 4'h0, 12, 1'b1,
                          8'(3 + (12 * 9) + 60 + f) >> 4, "R9");
            end else begin
                plain_frame(60 + f);
            end
        end
        // Lower nibble of frame 3 shows channel 18 from host (R4, R5).
        run_frame(80, -1, src_sel, -1, 4'h0, -1, 1'b1, 4'h0, "R4");
        for (int f = 1; f < 4; f++) begin
            if (f == 3) run_frame(80 + f, -1, src_sel, -1, 4'h0, 8, 1'b0, 4'h9, "R5");
            else plain_frame(80 + f);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule